// File: doc/BRIEF.md
# Data address breakpoint matcher

This block sits beside the load/store path and inspects every data access, whether it comes from an explicit load or store or from an implicit access made by some other operation. It holds a small set of breakpoint slots. Each slot has a full byte address and a two-bit mode that says which kinds of access the slot checks. A slot fires when the access kind is one its mode accepts and the programmed byte lies anywhere within the bytes the access touches. An access that starts below the programmed byte can therefore still fire the slot, and misaligned accesses are handled the same way as aligned ones.

Software or a debug unit loads the slots through a single-cycle write port. The access side presents a valid strobe, the start byte address, a size code, a write flag and a fault flag for the same access. The block returns one registered hit bit per slot and their OR. Each hit lasts exactly one cycle and follows the accepted access by one clock. An access that is flagged as faulting never produces a hit, so the fault takes priority.

Top module: `dbrk_match`

## Requirements
- R1: While reset is held and after it is released, every hit output is 0, every slot address is 0 and every slot mode is 00 (disabled). With no configuration, no access produces a hit.
- R2: When cfg_wr is 1 at a clock edge, cfg_kind=0 loads cfg_data into the address of slot cfg_idx, and cfg_kind=1 loads cfg_data[1:0] into its mode. An access presented at that same edge is matched against the old contents.
- R3: Mode encoding: 00 means the slot never fires, 01 means it checks writes only (acc_write=1), 10 means it checks reads only (acc_write=0), and 11 means it checks both.
- R4: The size code acc_size maps 0 to 1 byte, 1 to 2 bytes, 2 to 4 bytes, 3 to 8 bytes, 4 to 12 bytes and 5 to 16 bytes. Codes 6 and 7 never match.
- R5: An address match exists when the slot address A satisfies start <= A <= start+bytes-1, for any start alignment.
- R6: With slot address 0x100F and reads enabled, these reads hit: 1 byte at 0x100F, 2 at 0x100E, 4 at 0x100C and at 0x100D, 8 at 0x1008, 12 at 0x1004, and 16 at 0x1000. A 12-byte read at 0x1000 does not hit.
- R7: An access that runs past 0xFFFFFFFF covers only the bytes up to 0xFFFFFFFF. It never matches a slot at a low address that a wrapped end would reach.
- R8: A hit appears in the cycle after the clock edge at which acc_valid=1 was sampled, and lasts one cycle. Without a valid access there is no hit.
- R9: When acc_fault=1 at the same edge as a valid access, no slot hit is produced for that access.
- R10: hit_any is 1 exactly when at least one bit of hit is 1.
- R11: Slots are matched independently. Two slots at the same address with different modes each respond according to their own mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_kind | input | 1 | 0 writes slot address, 1 writes slot mode |
| cfg_idx | input | IW | Slot selected by a configuration write |
| cfg_data | input | AW | Write data (mode uses bits 1:0) |
| acc_valid | input | 1 | Data access present this cycle |
| acc_addr | input | AW | Start byte address of the access |
| acc_size | input | 3 | Size code (see R4) |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_fault | input | 1 | Access is faulting; suppresses its hits |
| hit | output | NBP | Registered per-slot hit pulse |
| hit_any | output | 1 | OR of all slot hits |

## Verification
The matcher is driven with the worked 0x100F read examples and the 12-byte near-miss. These separate coverage of the whole byte range from a start-address-only compare. A sweep of start addresses around a slot address, across every size code, exposes off-by-one errors at both ends of the range and confirms that the reserved codes are rejected. Read and write accesses under each mode, with two slots sharing one address, show whether qualification is per slot and per direction. Accesses near the top of the address space, together with a configuration write landing on the same edge as an access, test the wrap handling and the old-contents rule.

// File: rtl/dbrk_match.sv
module dbrk_match #(
  parameter int AW  = 32,
  parameter int NBP = 2,
  localparam int IW = (NBP > 1) ? $clog2(NBP) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_wr,
  input  logic           cfg_kind,
  input  logic [IW-1:0]  cfg_idx,
  input  logic [AW-1:0]  cfg_data,
  input  logic           acc_valid,
  input  logic [AW-1:0]  acc_addr,
  input  logic [2:0]     acc_size,
  input  logic           acc_write,
  input  logic           acc_fault,
  output logic [NBP-1:0] hit,
  output logic           hit_any
);

  logic [AW-1:0] bp_addr [NBP];
  logic [1:0]    bp_mode [NBP];
  logic [4:0]    span;
  logic [NBP-1:0] hit_d;

  always_comb begin
    case (acc_size)
      3'd0:    span = 5'd1;
      3'd1:    span = 5'd2;
      3'd2:    span = 5'd4;
      3'd3:    span = 5'd8;
      3'd4:    span = 5'd12;
      3'd5:    span = 5'd16;
      default: span = 5'd0;
    endcase
  end

  wire          size_ok = (span != 5'd0);
  wire [AW:0]   lo      = {1'b0, acc_addr};
  wire [AW:0]   hi      = lo + {{(AW-4){1'b0}}, span} - (AW+1)'(1);
  wire          live    = acc_valid && !acc_fault && size_ok;

  for (genvar i = 0; i < NBP; i++) begin : g_slot
    wire [AW:0] tgt  = {1'b0, bp_addr[i]};
    wire        qual = acc_write ? bp_mode[i][0] : bp_mode[i][1];
    assign hit_d[i] = live && qual && (tgt >= lo) && (tgt <= hi);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bp_addr[i] <= '0;
        bp_mode[i] <= 2'b00;
      end else if (cfg_wr && cfg_idx == IW'(i)) begin
        if (cfg_kind) bp_mode[i] <= cfg_data[1:0];
        else          bp_addr[i] <= cfg_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) hit <= '0;
    else        hit <= hit_d;
  end

  assign hit_any = |hit;

endmodule

// File: rtl/dbrk_match_chk.sv
module dbrk_match_chk #(
  parameter int AW  = 32,
  parameter int NBP = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           acc_valid,
  input logic           acc_fault,
  input logic           acc_write,
  input logic [AW-1:0]  acc_addr,
  input logic [AW-1:0]  bp_addr [NBP],
  input logic [1:0]     bp_mode [NBP],
  input logic [NBP-1:0] hit,
  input logic           hit_any
);

  // R9
  fault_blocks_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc_valid && acc_fault) |-> hit == '0);

  // R10
  any_needs_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_any |-> $past(acc_valid && !acc_fault));

  for (genvar i = 0; i < NBP; i++) begin : g_chk
    // R8
    hit_needs_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit[i] |-> $past(acc_valid));

    // R5
    hit_not_below_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit[i] |-> ($past(bp_addr[i]) >= $past(acc_addr)));

    // R3
    hit_mode_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit[i] |-> ($past(bp_mode[i]) != 2'b00));

    // R3
    hit_dir_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit[i] |-> ($past(acc_write) ? $past(bp_mode[i][0]) : $past(bp_mode[i][1])));
  end

endmodule

bind dbrk_match dbrk_match_chk #(.AW(AW), .NBP(NBP)) u_chk (.*);

// File: tb/dbrk_match_tb.sv
`timescale 1ns/1ps
module dbrk_match_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0, cfg_kind = 1'b0;
  logic [0:0]  cfg_idx = '0;
  logic [31:0] cfg_data = '0;
  logic        acc_valid = 1'b0, acc_write = 1'b0, acc_fault = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [2:0]  acc_size = '0;
  logic [1:0]  hit;
  logic        hit_any;

  always #2.5 clk = ~clk;

  dbrk_match u_dut (.clk, .rst_n, .cfg_wr, .cfg_kind, .cfg_idx, .cfg_data,
    .acc_valid, .acc_addr, .acc_size, .acc_write, .acc_fault, .hit, .hit_any);

  int total = 0, bad = 0;
  string cur_req = "R1";
  longint m_addr [2];
  int     m_mode [2];
  logic [1:0] exp_hit;

  function automatic int bytes_of(int c);
    case (c)
      0: return 1; 1: return 2; 2: return 4;
      3: return 8; 4: return 12; 5: return 16;
      default: return 0;
    endcase
  endfunction

  function automatic bit ref_hit(int i, longint a, int c, bit w);
    int n = bytes_of(c);
    bit q = w ? m_mode[i][0] : m_mode[i][1];
    if (!q || n == 0) return 1'b0;
    return (m_addr[i] >= a) && (m_addr[i] <= a + n - 1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_hit <= '0;
      for (int i = 0; i < 2; i++) begin m_addr[i] <= 0; m_mode[i] <= 0; end
    end else begin
      for (int i = 0; i < 2; i++)
        exp_hit[i] <= acc_valid && !acc_fault &&
                      ref_hit(i, longint'({32'h0, acc_addr}), int'(acc_size), acc_write);
      if (cfg_wr) begin
        if (cfg_kind) m_mode[cfg_idx] <= int'(cfg_data[1:0]);
        else          m_addr[cfg_idx] <= longint'({32'h0, cfg_data});
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    check({cur_req, " hit"}, 32'(hit), 32'(exp_hit));
    check("R10 hit_any", 32'(hit_any), 32'(|exp_hit));
  end

  task automatic cfg(int idx, bit kind, logic [31:0] d);
    cfg_wr = 1'b1; cfg_idx = 1'(idx); cfg_kind = kind; cfg_data = d;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
  endtask

  task automatic acc(logic [31:0] a, int c, bit w, bit f);
    acc_valid = 1'b1; acc_addr = a; acc_size = 3'(c); acc_write = w; acc_fault = f;
    @(posedge clk); #1;
    acc_valid = 1'b0; acc_fault = 1'b0;
  endtask

  task automatic acc_expect(logic [31:0] a, int c, bit w, logic [1:0] e, string req);
    acc(a, c, w, 1'b0);
    @(negedge clk);
    check(req, 32'(hit), 32'(e));
    @(posedge clk); #1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset hit", 32'(hit), 32'h0);
    check("R1 reset hit_any", 32'(hit_any), 32'h0);
    @(posedge clk); #1; rst_n = 1'b1;

    cur_req = "R1";
    acc_expect(32'h0, 5, 1'b0, 2'b00, "R1 disabled slots");
    acc_expect(32'h0, 0, 1'b1, 2'b00, "R1 disabled slots write");

    cur_req = "R2";
    cfg(0, 1'b0, 32'h100F);
    cfg_wr = 1'b1; cfg_idx = 1'b0; cfg_kind = 1'b1; cfg_data = 32'h2;
    acc(32'h100F, 0, 1'b0, 1'b0);
    cfg_wr = 1'b0;
    @(negedge clk); check("R2 old mode on same edge", 32'(hit), 32'h0);
    @(posedge clk); #1;
    acc_expect(32'h100F, 0, 1'b0, 2'b01, "R2 new mode active");

    cur_req = "R6";
    acc_expect(32'h100E, 1, 1'b0, 2'b01, "R6 short");
    acc_expect(32'h100C, 2, 1'b0, 2'b01, "R6 word aligned");
    acc_expect(32'h100D, 2, 1'b0, 2'b01, "R6 word misaligned");
    acc_expect(32'h1008, 3, 1'b0, 2'b01, "R6 long");
    acc_expect(32'h1004, 4, 1'b0, 2'b01, "R6 triple");
    acc_expect(32'h1000, 5, 1'b0, 2'b01, "R6 quad");
    acc_expect(32'h1000, 4, 1'b0, 2'b00, "R6 triple miss");

    cur_req = "R3";
    acc_expect(32'h100F, 0, 1'b1, 2'b00, "R3 read-only ignores write");
    cfg(0, 1'b1, 32'h1);
    acc_expect(32'h100F, 0, 1'b1, 2'b01, "R3 write-only write");
    acc_expect(32'h100F, 0, 1'b0, 2'b00, "R3 write-only read");
    cfg(0, 1'b1, 32'h3);
    acc_expect(32'h100C, 2, 1'b0, 2'b01, "R3 both read");
    acc_expect(32'h100C, 2, 1'b1, 2'b01, "R3 both write");
    cfg(0, 1'b1, 32'h0);
    acc_expect(32'h100C, 2, 1'b1, 2'b00, "R3 disabled");

    cur_req = "R4";
    cfg(0, 1'b1, 32'h3);
    acc_expect(32'h100F, 6, 1'b0, 2'b00, "R4 code 6");
    acc_expect(32'h100F, 7, 1'b1, 2'b00, "R4 code 7");
    acc_expect(32'h1000, 5, 1'b1, 2'b01, "R4 code 5");

    cur_req = "R5";
    cfg(0, 1'b0, 32'h2005);
    for (int s = 32'h1FF0; s <= 32'h2008; s++)
      for (int c = 0; c < 8; c++) begin
        acc(32'(s), c, c[0], 1'b0);
      end
    @(posedge clk); #1;

    cur_req = "R8";
    acc(32'h2005, 0, 1'b0, 1'b0);
    acc(32'h2000, 3, 1'b1, 1'b0);
    acc(32'h3000, 3, 1'b1, 1'b0);
    @(negedge clk); check("R8 single pulse", 32'(hit), 32'h0);
    @(posedge clk); #1;

    cur_req = "R9";
    acc(32'h2005, 0, 1'b0, 1'b1);
    @(negedge clk); check("R9 fault suppresses", 32'(hit), 32'h0);
    @(posedge clk); #1;
    acc_expect(32'h2005, 0, 1'b0, 2'b01, "R9 no fault hits");

    cur_req = "R7";
    cfg(1, 1'b0, 32'h2);
    cfg(1, 1'b1, 32'h3);
    acc_expect(32'hFFFF_FFF8, 5, 1'b0, 2'b00, "R7 no wrap match");
    cfg(1, 1'b0, 32'hFFFF_FFFF);
    acc_expect(32'hFFFF_FFF8, 5, 1'b0, 2'b10, "R7 top byte match");
    acc_expect(32'hFFFF_FFFF, 2, 1'b1, 2'b10, "R7 top start");

    cur_req = "R11";
    cfg(1, 1'b0, 32'h2005);
    cfg(1, 1'b1, 32'h2);
    cfg(0, 1'b1, 32'h1);
    acc_expect(32'h2004, 1, 1'b0, 2'b10, "R11 read slot1 only");
    acc_expect(32'h2004, 1, 1'b1, 2'b01, "R11 write slot0 only");
    cfg(0, 1'b1, 32'h3);
    acc_expect(32'h2000, 5, 1'b0, 2'b11, "R11 both slots");

    repeat (3) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule